// File: doc/BRIEF.md
# Error Message Reporting Chain

This block takes the per-frame error message that an error-detection engine produces and passes it on to user logic. When a frame fails its check, the engine presents a 67-bit message together with a one-cycle valid strobe. The block holds that message in a capture register. One cycle later it copies the message into an update register. User logic then parallel-loads a shift register from the update register and unloads the copy one bit per cycle, least significant bit first.

A one-cycle error flag tells user logic that a fresh message is waiting in the update register. Between two flags the line stays low for at least a fixed quiet window. A report that arrives inside that window is held and is flagged as soon as the window ends. A newer report replaces an older one that has not been flagged yet.

A clock-enable qualifies the parallel load. While a qualified load is in progress, the copy into the update register is deferred, so a read and a write never meet. A separate free-running divider produces a pacing tick every 2^n cycles for the engine, with n from 1 to 8.

Top module: `emr_report_chain`

## Requirements
- R1: The message path is MSG_W bits wide (default 67), and `emr_in` is captured in the capture register on every cycle in which `emr_valid` is high.
- R2: When the update is not blocked, the update register holds the message that was captured on the clock edge before it. A strobe in cycle t therefore reaches the update register at the end of cycle t+1.
- R3: In a cycle with both `upd_ce` and `shift_load` high, the update register keeps its value, and any pending copy is made in the first cycle without that combination. A `shift_load` with `upd_ce` low is ignored.
- R4: A qualified load (`shift_load` and `upd_ce` both high) copies the update register into the shift register. `shift_out` is bit 0 of the shift register. Each cycle with `shift_en` high and no qualified load shifts the register one place toward bit 0 and fills the top with 0. A load takes priority over a shift.
- R5: `crc_error` is high for exactly one cycle per report. With no quiet window running, it is high in cycle t+3 for a strobe in cycle t, which is two cycles after the update register is written.
- R6: After each high cycle, `crc_error` stays low for at least LOW_MIN cycles (default 32). A report that arrives during that time is flagged in the first cycle after exactly LOW_MIN low cycles.
- R7: Reports that arrive during one quiet window produce a single flag, and the update register then holds the newest message.
- R8: `pace_tick` is high once every 2^(div_sel+1) cycles. `div_sel` is 3 bits, and codes 0 to 7 select divisors 2 to 256.
- R9: Reports are handled one after another for as long as reset stays low. A synchronous active-high `rst` clears every register, drops any pending report, and leaves `crc_error`, `shift_out` and `pace_tick` low while reset is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| emr_in | input | MSG_W | Error message from the detection engine |
| emr_valid | input | 1 | One-cycle strobe: `emr_in` holds a new message |
| div_sel | input | 3 | Pacing divider select; divisor is 2^(div_sel+1) |
| upd_ce | input | 1 | Clock-enable that qualifies a shift-register load |
| shift_load | input | 1 | Parallel-load the shift register from the update register |
| shift_en | input | 1 | Shift the shift register one bit toward bit 0 |
| shift_out | output | 1 | Serial message bit (bit 0 of the shift register) |
| crc_error | output | 1 | One-cycle flag: a new message is ready |
| pace_tick | output | 1 | Pacing tick for the detection engine |

## Verification
The flag path is tried with four kinds of input:
- An isolated report, which pins down the three-cycle latency.
- A report followed at once by two more inside the quiet window, which separates an exact 32-cycle hold from an early rise and shows whether a newer message replaces the pending one.
- A report held off by a long qualified load, which shows whether the update copy is deferred rather than lost or taken early.
- Random messages at random spacings with optional unloads, which compare each flag cycle against the larger of the latency and the window end.

The serial unload is compared bit by bit against the message that was sent. Loads without `upd_ce` are checked on an emptied register, so that an ignored load can be told apart from a real one. Every divider code is measured for its tick period, and a reset given while a report is in flight must leave no flag and an empty shift register.

// File: rtl/emr_pkg.sv
package emr_pkg;
    localparam int MSG_W_DEF   = 67;
    localparam int LOW_MIN_DEF = 32;
    localparam int DIV_LOG_DEF = 8;
endpackage

// File: rtl/emr_pace_div.sv
module emr_pace_div #(
    parameter int DIV_LOG = 8,
    parameter int SEL_W   = $clog2(DIV_LOG)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [SEL_W-1:0] sel,
    output logic             tick
);
    typedef struct packed {
        logic [DIV_LOG-1:0] cnt;
    } pace_t;

    pace_t pace_d, pace_q;
    logic [DIV_LOG-1:0] mask;

    always_comb begin
        mask = '0;
        for (int i = 0; i < DIV_LOG; i++) begin
            mask[i] = (i <= int'(sel));
        end
        tick       = ((pace_q.cnt & mask) == mask);
        pace_d     = pace_q;
        pace_d.cnt = pace_q.cnt + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) pace_q <= '0;
        else     pace_q <= pace_d;
    end
endmodule

// File: rtl/emr_flag_gate.sv
module emr_flag_gate #(
    parameter int LOW_MIN = 32,
    parameter int GAP_W   = $clog2(LOW_MIN + 1)
) (
    input  logic clk,
    input  logic rst,
    input  logic report_in,
    output logic flag
);
    typedef struct packed {
        logic             flag;
        logic             pend;
        logic [GAP_W-1:0] gap;
    } gate_t;

    gate_t gate_d, gate_q;

    always_comb begin
        gate_d = gate_q;
        if (gate_q.flag) begin
            gate_d.flag = 1'b0;
            gate_d.gap  = GAP_W'(LOW_MIN - 1);
        end else if (gate_q.gap != '0) begin
            gate_d.gap = gate_q.gap - 1'b1;
        end else if (gate_q.pend) begin
            gate_d.flag = 1'b1;
            gate_d.pend = 1'b0;
        end
        if (report_in) gate_d.pend = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) gate_q <= '0;
        else     gate_q <= gate_d;
    end

    assign flag = gate_q.flag;
endmodule

// File: rtl/emr_shift_unload.sv
module emr_shift_unload #(
    parameter int W = 67
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] src,
    input  logic         shift,
    output logic [W-1:0] word
);
    typedef struct packed {
        logic [W-1:0] sr;
    } unl_t;

    unl_t unl_d, unl_q;

    always_comb begin
        unl_d = unl_q;
        if (load)       unl_d.sr = src;
        else if (shift) unl_d.sr = {1'b0, unl_q.sr[W-1:1]};
    end

    always_ff @(posedge clk) begin
        if (rst) unl_q <= '0;
        else     unl_q <= unl_d;
    end

    assign word = unl_q.sr;
endmodule

// File: rtl/emr_report_chain.sv
module emr_report_chain import emr_pkg::*; #(
    parameter int MSG_W   = MSG_W_DEF,
    parameter int LOW_MIN = LOW_MIN_DEF,
    parameter int DIV_LOG = DIV_LOG_DEF,
    localparam int SEL_W  = $clog2(DIV_LOG)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [MSG_W-1:0] emr_in,
    input  logic             emr_valid,
    input  logic [SEL_W-1:0] div_sel,
    input  logic             upd_ce,
    input  logic             shift_load,
    input  logic             shift_en,
    output logic             shift_out,
    output logic             crc_error,
    output logic             pace_tick
);
    typedef struct packed {
        logic [MSG_W-1:0] emr;
        logic [MSG_W-1:0] upd;
        logic             pend;
    } chain_t;

    chain_t chain_d, chain_q;
    logic   upd_block, upd_wr;
    logic [MSG_W-1:0] upd_word, sh_word;

    always_comb begin
        upd_block = upd_ce && shift_load;
        upd_wr    = chain_q.pend && !upd_block;
        chain_d   = chain_q;
        if (upd_wr) begin
            chain_d.upd  = chain_q.emr;
            chain_d.pend = 1'b0;
        end
        if (emr_valid) begin
            chain_d.emr  = emr_in;
            chain_d.pend = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) chain_q <= '0;
        else     chain_q <= chain_d;
    end

    assign upd_word = chain_q.upd;

    emr_shift_unload #(.W(MSG_W)) u_shift (
        .clk   (clk),
        .rst   (rst),
        .load  (upd_block),
        .src   (upd_word),
        .shift (shift_en),
        .word  (sh_word)
    );

    emr_flag_gate #(.LOW_MIN(LOW_MIN)) u_gate (
        .clk       (clk),
        .rst       (rst),
        .report_in (upd_wr),
        .flag      (crc_error)
    );

    emr_pace_div #(.DIV_LOG(DIV_LOG)) u_pace (
        .clk  (clk),
        .rst  (rst),
        .sel  (div_sel),
        .tick (pace_tick)
    );

    assign shift_out = sh_word[0];
endmodule

// File: rtl/emr_report_chain_chk.sv
module emr_report_chain_chk #(
    parameter int MSG_W   = 67,
    parameter int LOW_MIN = 32
) (
    input logic             clk,
    input logic             rst,
    input logic [MSG_W-1:0] emr_in,
    input logic             emr_valid,
    input logic             upd_ce,
    input logic             shift_load,
    input logic             shift_en,
    input logic             crc_error,
    input logic             pace_tick,
    input logic [MSG_W-1:0] upd_word,
    input logic [MSG_W-1:0] sh_word
);
    localparam int LC_W = $clog2(LOW_MIN + 1);
    logic [LC_W-1:0] low_cnt;

    always_ff @(posedge clk) begin
        if (rst)                               low_cnt <= LC_W'(LOW_MIN);
        else if (crc_error)                    low_cnt <= '0;
        else if (low_cnt != LC_W'(LOW_MIN))    low_cnt <= low_cnt + 1'b1;
    end

    assert_upd_lag_R2: assert property (@(posedge clk) disable iff (rst)
        (emr_valid ##1 !(upd_ce && shift_load)) |=> (upd_word == $past(emr_in, 2)));

    assert_upd_hold_R3: assert property (@(posedge clk) disable iff (rst)
        (upd_ce && shift_load) |=> $stable(upd_word));

    assert_load_R4: assert property (@(posedge clk) disable iff (rst)
        (upd_ce && shift_load) |=> (sh_word == $past(upd_word)));

    assert_shift_R4: assert property (@(posedge clk) disable iff (rst)
        (shift_en && !(upd_ce && shift_load)) |=> (sh_word == ($past(sh_word) >> 1)));

    assert_pulse_R5: assert property (@(posedge clk) disable iff (rst)
        crc_error |=> !crc_error);

    assert_quiet_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(crc_error) |-> (low_cnt == LC_W'(LOW_MIN)));

    assert_tick_R8: assert property (@(posedge clk) disable iff (rst)
        pace_tick |=> !pace_tick);
endmodule

bind emr_report_chain emr_report_chain_chk #(.MSG_W(MSG_W), .LOW_MIN(LOW_MIN)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .emr_in     (emr_in),
    .emr_valid  (emr_valid),
    .upd_ce     (upd_ce),
    .shift_load (shift_load),
    .shift_en   (shift_en),
    .crc_error  (crc_error),
    .pace_tick  (pace_tick),
    .upd_word   (upd_word),
    .sh_word    (sh_word)
);

// File: tb/tb_emr_report_chain.sv
module tb_emr_report_chain;
    localparam int W    = 67;
    localparam int LOWN = 32;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [W-1:0] emr_in = '0;
    logic         emr_valid = 1'b0;
    logic [2:0]   div_sel = 3'd0;
    logic         upd_ce = 1'b0;
    logic         shift_load = 1'b0;
    logic         shift_en = 1'b0;
    logic         shift_out, crc_error, pace_tick;

    int  checks = 0;
    int  errors = 0;
    int  cyc = 0;
    int  last_hi = -1000;
    bit  done = 1'b0;

    always #10 clk = ~clk;

    emr_report_chain dut (
        .clk(clk), .rst(rst), .emr_in(emr_in), .emr_valid(emr_valid),
        .div_sel(div_sel), .upd_ce(upd_ce), .shift_load(shift_load),
        .shift_en(shift_en), .shift_out(shift_out), .crc_error(crc_error),
        .pace_tick(pace_tick)
    );

    function automatic logic [W-1:0] rand_msg();
        return W'({$urandom(), $urandom(), $urandom()});
    endfunction

    function automatic int exp_rise(int s, int h);
        return (s + 3 > h + LOWN + 1) ? s + 3 : h + LOWN + 1;
    endfunction

    function automatic int exp_period(int k);
        return 2 << k;
    endfunction

    task automatic step();
        @(negedge clk);
        cyc++;
    endtask

    task automatic chk(bit ok, string req, string what, logic [W-1:0] act, logic [W-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic send(logic [W-1:0] m, output int s);
        emr_in    = m;
        emr_valid = 1'b1;
        s         = cyc;
        step();
        emr_valid = 1'b0;
    endtask

    task automatic wait_high(output int at);
        int n = 0;
        while (!crc_error && n < 400) begin
            step();
            n++;
        end
        at = cyc;
    endtask

    task automatic unload(output logic [W-1:0] v);
        upd_ce     = 1'b1;
        shift_load = 1'b1;
        step();
        shift_load = 1'b0;
        upd_ce     = 1'b0;
        shift_en   = 1'b1;
        for (int i = 0; i < W; i++) begin
            v[i] = shift_out;
            step();
        end
        shift_en = 1'b0;
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL R9 watchdog: actual hung expected finished");
            summary();
            $finish;
        end
    end

    initial begin
        logic [W-1:0] a, b, c, dd, e, got;
        int s, at, r, hits, n;
        void'($urandom(32'd4242));

        // reset state (R9), sampled while reset is still held
        repeat (3) step();
        chk(crc_error == 1'b0, "R9", "crc_error in reset", W'(crc_error), '0);
        chk(shift_out == 1'b0, "R9", "shift_out in reset", W'(shift_out), '0);
        chk(pace_tick == 1'b0, "R9", "pace_tick in reset", W'(pace_tick), '0);
        rst = 1'b0;
        step();

        // single report: latency and pulse width (R1, R5)
        a = rand_msg();
        a[0] = 1'b1;
        send(a, s);
        chk(crc_error == 1'b0, "R5", "flag at t+1", W'(crc_error), '0);
        step();
        chk(crc_error == 1'b0, "R5", "flag at t+2", W'(crc_error), '0);
        step();
        chk(crc_error == 1'b1, "R5", "flag at t+3", W'(crc_error), W'(1));
        last_hi = cyc;
        step();
        chk(crc_error == 1'b0, "R5", "flag after pulse", W'(crc_error), '0);
        unload(got);
        chk(got == a, "R1", "unloaded message", got, a);

        // a load without the clock-enable is ignored (R3); a qualified load works (R4)
        shift_load = 1'b1;
        step();
        shift_load = 1'b0;
        chk(shift_out == 1'b0, "R3", "load without upd_ce", W'(shift_out), '0);
        upd_ce     = 1'b1;
        shift_load = 1'b1;
        step();
        upd_ce     = 1'b0;
        shift_load = 1'b0;
        chk(shift_out == 1'b1, "R4", "qualified load bit0", W'(shift_out), W'(1));

        // a long qualified load defers the update copy (R3)
        b = rand_msg();
        b[0] = 1'b0;
        send(b, s);
        upd_ce     = 1'b1;
        shift_load = 1'b1;
        hits = 0;
        for (int i = 0; i < 10; i++) begin
            step();
            if (crc_error) hits++;
        end
        chk(hits == 0, "R3", "flag while blocked", W'(hits), '0);
        chk(shift_out == 1'b1, "R3", "old copy kept while blocked", W'(shift_out), W'(1));
        upd_ce     = 1'b0;
        shift_load = 1'b0;
        r = cyc;
        wait_high(at);
        chk(at == r + 2, "R3", "flag after release", W'(at - r), W'(2));
        last_hi = at;
        unload(got);
        chk(got == b, "R3", "deferred message", got, b);

        // quiet window and overwrite of a pending report (R6, R7)
        c = rand_msg();
        send(c, s);
        wait_high(at);
        chk(at == exp_rise(s, last_hi), "R5", "flag latency", W'(at - s), W'(3));
        last_hi = at;
        dd = rand_msg();
        send(dd, s);
        repeat (3) step();
        e = rand_msg();
        send(e, s);
        wait_high(at);
        chk(at == last_hi + LOWN + 1, "R6", "rise after quiet window",
            W'(at - last_hi - 1), W'(LOWN));
        last_hi = at;
        hits = 0;
        for (int i = 0; i < 40; i++) begin
            step();
            if (crc_error) hits++;
        end
        chk(hits == 0, "R7", "single flag for overwritten reports", W'(hits), '0);
        unload(got);
        chk(got == e, "R7", "newest message kept", got, e);

        // pacing divider periods (R8)
        for (int k = 0; k < 8; k++) begin
            div_sel = 3'(k);
            n = 0;
            step();
            while (!pace_tick && n < 600) begin
                step();
                n++;
            end
            n = 0;
            step();
            n = 1;
            while (!pace_tick && n < 600) begin
                step();
                n++;
            end
            chk(n == exp_period(k), "R8", $sformatf("period for code %0d", k),
                W'(n), W'(exp_period(k)));
        end

        // random stream of reports (R9, R6, R4)
        for (int it = 0; it < 24; it++) begin
            n = int'($urandom() % 51);
            repeat (n) step();
            c = rand_msg();
            send(c, s);
            wait_high(at);
            chk(at == exp_rise(s, last_hi), "R9", $sformatf("random flag cycle %0d", it),
                W'(at), W'(exp_rise(s, last_hi)));
            last_hi = at;
            if ($urandom() % 2 == 0) begin
                unload(got);
                chk(got == c, "R4", $sformatf("random unload %0d", it), got, c);
            end
        end

        // reset in flight drops the report and clears the shift register (R9)
        repeat (40) step();
        c = rand_msg();
        send(c, s);
        rst = 1'b1;
        repeat (2) step();
        rst = 1'b0;
        hits = 0;
        for (int i = 0; i < 10; i++) begin
            step();
            if (crc_error) hits++;
        end
        chk(hits == 0, "R9", "no flag after reset", W'(hits), '0);
        unload(got);
        chk(got == '0, "R9", "shift register cleared by reset", got, '0);

        done = 1'b1;
        summary();
        $finish;
    end
endmodule